// File: doc/BRIEF.md
# Fixed Off-Time Chopper Controller

This block is the digital control core of a current-chopping motor pre-driver, cut down to one selected source/sink switch pair. An active-low enable acts as an external PWM. While the enable is low the pair conducts. While it is high the source switch is chopped off and the winding current decays slowly through the synchronous-rectification switch. A current-trip comparator, synchronized inside the block, clears the source when the winding current reaches its limit. The source then stays off for a fixed off-time before it turns on again.

The trip input is masked for a short blanking window. The window opens on three events: an enable falling edge, a direction change, and the end of every off-time. If the enable stays high for a long timeout, every gate output is dropped, and the block waits for the next enable falling edge. An active-low brake input turns all sinks on and all sources off, and it wins over every other input. Durations come from a clock-frequency parameter. At the default 10 MHz they are 250 cycles of off-time, 15 cycles of blanking and 30,000 cycles of enable timeout.

Top module: `chop_ctrl`

## Requirements
- R1: After reset all gate outputs are 0 and `gate_off` is 1. This holds until the first falling edge of the synchronized enable.
- R2: With the enable low, brake inactive and no trip accepted, `src_on`=1, `snk_on`=1, `sr_on`=0, `brake_all`=0 and `gate_off`=0.
- R3: A trip seen while the source is on, the enable is low and no blanking window is open turns the source off. The outputs become `src_on`=0, `snk_on`=1 and `sr_on`=1.
- R4: After an accepted trip the source stays off for exactly OFF_CYC cycles (250 by default). It then turns back on, provided the enable is still low.
- R5: For BLANK_CYC cycles (15 by default) the trip input is ignored. This window follows every enable falling edge, every direction change and every return from the off-time.
- R6: Enable high chops the source: `src_on`=0, `snk_on`=1, `sr_on`=1. A following enable low restores the drive outputs of R2.
- R7: Enable held high for IDLE_CYC cycles (30,000 by default) sets `gate_off`=1 with all other outputs 0. The next enable falling edge leaves this state.
- R8: Brake low forces `brake_all`=1, `snk_on`=1, `src_on`=0, `sr_on`=0 and `gate_off`=0, whatever the other inputs are. A trip seen during brake is never accepted.
- R9: Every input passes a two-flop synchronizer. The outputs answer an input change after the third rising clock edge and not after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_n_in | input | 1 | Asynchronous active-low enable (external PWM) |
| dir_in | input | 1 | Asynchronous direction select |
| brake_n_in | input | 1 | Asynchronous active-low brake |
| trip_in | input | 1 | Asynchronous current-trip comparator output |
| src_on | output | 1 | Selected source switch on |
| snk_on | output | 1 | Selected sink switch on |
| sr_on | output | 1 | Synchronous-rectification switch on during decay |
| brake_all | output | 1 | All sink switches on (brake) |
| gate_off | output | 1 | All gates disabled after enable timeout |

## Verification
A wrong phase register shows at the gate outputs three edges after the input that exposes it. The outputs are registered from the next phase, so a trip accepted inside a blanking window drops `src_on` one edge after the synchronized trip. A mis-loaded off-time counter moves the source's return by the counting error, so the bench checks the return just before and just after OFF_CYC. A stuck brake overlay or idle counter appears as the wrong `brake_all` or `gate_off` level at the very next sample. A missed blanking start on a direction change lets a held trip clear the source within a few cycles.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [1:0] {
    PH_OFFLINE = 2'd0,
    PH_DRIVE   = 2'd1,
    PH_RECIRC  = 2'd2,
    PH_CHOP    = 2'd3
  } phase_t;

  typedef struct packed {
    logic src;
    logic snk;
    logic sr;
    logic brk;
    logic goff;
  } gates_t;

endpackage

// File: rtl/chop_sync.sv
module chop_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/chop_timer.sv
module chop_timer #(
  parameter int COUNT = 250,
  localparam int CW = $clog2(COUNT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic busy,
  output logic last
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= CW'(COUNT);
    else if (cnt != '0)
      cnt <= cnt - CW'(1);
  end

  assign busy = (cnt != '0);
  assign last = (cnt == CW'(1));
endmodule

// File: rtl/chop_idle.sv
module chop_idle #(
  parameter int LIMIT = 30000,
  localparam int IW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic high,
  output logic expire
);
  logic [IW-1:0] cnt;

  assign expire = high && (cnt == IW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || !high)
      cnt <= '0;
    else if (!expire)
      cnt <= cnt + IW'(1);
  end
endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl #(
  parameter int CLK_HZ = 10_000_000,
  localparam int OFF_CYC   = CLK_HZ / 40_000,
  localparam int BLANK_CYC = (CLK_HZ * 3) / 2_000_000,
  localparam int IDLE_CYC  = (CLK_HZ / 1_000) * 3
) (
  input  logic clk,
  input  logic rst,
  input  logic en_n_in,
  input  logic dir_in,
  input  logic brake_n_in,
  input  logic trip_in,
  output logic src_on,
  output logic snk_on,
  output logic sr_on,
  output logic brake_all,
  output logic gate_off
);
  import chop_pkg::*;

  logic [3:0] raw_v, syn_v;
  logic en_n_s, brk_n_s, dir_s, trip_s;
  logic en_n_d, dir_d;
  logic en_fall, dir_chg;
  logic blank_busy, blank_last, blank_start;
  logic off_busy, off_last, off_load;
  logic idle_expire, trip_ok;
  phase_t phase, phase_nxt;
  gates_t g_nxt;

  assign raw_v = {trip_in, dir_in, brake_n_in, en_n_in};

  chop_sync #(.W(4), .RST_VAL(4'b0011)) u_sync (
    .clk(clk), .rst(rst), .d(raw_v), .q(syn_v)
  );

  assign en_n_s  = syn_v[0];
  assign brk_n_s = syn_v[1];
  assign dir_s   = syn_v[2];
  assign trip_s  = syn_v[3];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_n_d <= 1'b1;
      dir_d  <= 1'b0;
    end else begin
      en_n_d <= en_n_s;
      dir_d  <= dir_s;
    end
  end

  assign en_fall = en_n_d && !en_n_s;
  assign dir_chg = dir_d ^ dir_s;

  chop_timer #(.COUNT(BLANK_CYC)) u_blank (
    .clk(clk), .rst(rst), .load(blank_start),
    .busy(blank_busy), .last(blank_last)
  );

  chop_timer #(.COUNT(OFF_CYC)) u_off (
    .clk(clk), .rst(rst), .load(off_load),
    .busy(off_busy), .last(off_last)
  );

  chop_idle #(.LIMIT(IDLE_CYC)) u_idle (
    .clk(clk), .rst(rst), .high(en_n_s), .expire(idle_expire)
  );

  assign trip_ok = trip_s && !blank_busy && brk_n_s;

  always_comb begin
    phase_nxt = phase;
    unique case (phase)
      PH_OFFLINE: if (en_fall)  phase_nxt = PH_DRIVE;
      PH_DRIVE: begin
        if (en_n_s)             phase_nxt = PH_CHOP;
        else if (trip_ok)       phase_nxt = PH_RECIRC;
      end
      PH_RECIRC: begin
        if (en_n_s)             phase_nxt = PH_CHOP;
        else if (off_last)      phase_nxt = PH_DRIVE;
      end
      PH_CHOP:    if (!en_n_s)  phase_nxt = PH_DRIVE;
      default:                  phase_nxt = PH_OFFLINE;
    endcase
    if (idle_expire)            phase_nxt = PH_OFFLINE;
  end

  assign blank_start = ((phase_nxt == PH_DRIVE) && (phase != PH_DRIVE)) || dir_chg;
  assign off_load    = (phase == PH_DRIVE) && (phase_nxt == PH_RECIRC);

  always_comb begin
    g_nxt = '0;
    if (!brk_n_s) begin
      g_nxt.snk = 1'b1;
      g_nxt.brk = 1'b1;
    end else begin
      unique case (phase_nxt)
        PH_DRIVE:  begin g_nxt.src = 1'b1; g_nxt.snk = 1'b1; end
        PH_RECIRC,
        PH_CHOP:   begin g_nxt.snk = 1'b1; g_nxt.sr  = 1'b1; end
        default:   g_nxt.goff = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_OFFLINE;
      src_on    <= 1'b0;
      snk_on    <= 1'b0;
      sr_on     <= 1'b0;
      brake_all <= 1'b0;
      gate_off  <= 1'b1;
    end else begin
      phase     <= phase_nxt;
      src_on    <= g_nxt.src;
      snk_on    <= g_nxt.snk;
      sr_on     <= g_nxt.sr;
      brake_all <= g_nxt.brk;
      gate_off  <= g_nxt.goff;
    end
  end

  logic unused_ok;
  assign unused_ok = blank_last ^ off_busy;
endmodule

// File: rtl/chop_ctrl_chk.sv
module chop_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic en_n_s,
  input logic brk_n_s,
  input logic trip_s,
  input logic dir_chg,
  input logic blank_busy,
  input logic src_on,
  input logic snk_on,
  input logic sr_on,
  input logic brake_all,
  input logic gate_off
);
  // R8
  brake_force_chk: assert property (@(posedge clk) disable iff (rst)
    !brk_n_s |=> (brake_all && snk_on && !src_on && !sr_on && !gate_off));

  // R3
  trip_cut_chk: assert property (@(posedge clk) disable iff (rst)
    (src_on && trip_s && !blank_busy && !en_n_s && brk_n_s && !dir_chg)
      |=> (!src_on && sr_on && snk_on));

  // R5
  blank_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (src_on && blank_busy && !en_n_s && brk_n_s) |=> src_on);

  // R6
  chop_src_chk: assert property (@(posedge clk) disable iff (rst)
    (en_n_s && brk_n_s) |=> !src_on);

  // R7
  always @(posedge clk) begin
    if (!rst) begin
      offline_quiet_chk: assert (!gate_off || (!src_on && !snk_on && !sr_on && !brake_all));
    end
  end
endmodule

bind chop_ctrl chop_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .en_n_s(en_n_s), .brk_n_s(brk_n_s), .trip_s(trip_s),
  .dir_chg(dir_chg), .blank_busy(blank_busy), .src_on(src_on), .snk_on(snk_on),
  .sr_on(sr_on), .brake_all(brake_all), .gate_off(gate_off)
);

// File: tb/chop_ctrl_bench.sv
module chop_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_n_in = 1'b1, dir_in = 1'b0, brake_n_in = 1'b1, trip_in = 1'b0;
  logic src_on, snk_on, sr_on, brake_all, gate_off;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    string      req;
    logic [4:0] exp;
  } item_t;
  item_t sb_q[$];

  // output vector order: {src_on, snk_on, sr_on, brake_all, gate_off}
  localparam logic [4:0] V_OFFLINE = 5'b00001;
  localparam logic [4:0] V_DRIVE   = 5'b11000;
  localparam logic [4:0] V_DECAY   = 5'b01100;
  localparam logic [4:0] V_BRAKE   = 5'b01010;

  always #4 clk = ~clk;

  chop_ctrl u_chop_ctrl (
    .clk(clk), .rst(rst), .en_n_in(en_n_in), .dir_in(dir_in),
    .brake_n_in(brake_n_in), .trip_in(trip_in), .src_on(src_on),
    .snk_on(snk_on), .sr_on(sr_on), .brake_all(brake_all), .gate_off(gate_off)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(string req, logic [4:0] e);
    item_t it;
    it.req = req;
    it.exp = e;
    sb_q.push_back(it);
  endtask

  // monitor: compares queued expectations shortly after each falling edge
  always @(negedge clk) begin
    #1;
    while (sb_q.size() > 0) begin
      item_t it;
      logic [4:0] act;
      it = sb_q.pop_front();
      act = {src_on, snk_on, sr_on, brake_all, gate_off};
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s: actual=%b expected=%b", it.req, act, it.exp);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(5);
    rst = 1'b0;
    tick(2);
    expect_out("R1 reset state", V_OFFLINE);

    // first enable fall: latency then drive
    en_n_in = 1'b0;
    tick(2);
    expect_out("R9 no response after two edges", V_OFFLINE);
    tick(1);
    expect_out("R2 drive after third edge", V_DRIVE);

    // trip inside blanking window is ignored
    trip_in = 1'b1;
    tick(8);
    expect_out("R5 trip ignored after enable fall", V_DRIVE);
    tick(12);
    expect_out("R3 trip clears source", V_DECAY);
    trip_in = 1'b0;
    tick(240);
    expect_out("R4 still off before off-time end", V_DECAY);
    tick(10);
    expect_out("R4 source back after off-time", V_DRIVE);

    // direction change opens a fresh blanking window
    tick(20);
    dir_in = 1'b1;
    tick(4);
    trip_in = 1'b1;
    tick(6);
    expect_out("R5 trip ignored after direction change", V_DRIVE);
    tick(20);
    expect_out("R3 trip after direction blanking", V_DECAY);
    trip_in = 1'b0;
    tick(260);
    expect_out("R4 drive resumed", V_DRIVE);

    // enable chop and restore
    en_n_in = 1'b1;
    tick(4);
    expect_out("R6 chop on enable high", V_DECAY);
    en_n_in = 1'b0;
    tick(4);
    expect_out("R6 drive on enable low", V_DRIVE);

    // brake with trip held: trip never accepted
    tick(30);
    brake_n_in = 1'b0;
    trip_in = 1'b1;
    tick(4);
    expect_out("R8 brake outputs", V_BRAKE);
    tick(30);
    expect_out("R8 brake held with trip", V_BRAKE);
    trip_in = 1'b0;
    brake_n_in = 1'b1;
    tick(4);
    expect_out("R8 trip during brake ignored", V_DRIVE);

    // long enable-high timeout
    en_n_in = 1'b1;
    tick(4);
    expect_out("R6 chop before timeout", V_DECAY);
    tick(29000);
    expect_out("R7 not yet disabled", V_DECAY);
    tick(1500);
    expect_out("R7 disabled after timeout", V_OFFLINE);
    brake_n_in = 1'b0;
    tick(4);
    expect_out("R8 brake overrides disabled", V_BRAKE);
    brake_n_in = 1'b1;
    tick(4);
    expect_out("R7 disabled again after brake", V_OFFLINE);

    // recovery on enable fall, with blanking
    en_n_in = 1'b0;
    tick(4);
    expect_out("R7 recovery on enable fall", V_DRIVE);
    trip_in = 1'b1;
    tick(5);
    expect_out("R5 trip ignored after recovery", V_DRIVE);
    tick(20);
    expect_out("R3 trip after recovery blanking", V_DECAY);
    trip_in = 1'b0;
    tick(3);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule